// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block watches the processor's instruction fetches and its load/store traffic and compares them against a bank of programmable breakpoints. It has six instruction channels, which compare the fetch virtual address, and two data channels, which compare the access virtual address. Each data channel can be limited to loads, to stores or to both. It can also require the transferred value to match a programmed value.

Every channel compares through a mask in which a 1 bit means "don't care", so a single channel can cover an aligned address range. When any enabled channel matches, the block raises a debug break request in the same cycle as the fetch or access strobe. The channel's sticky hit bit records which breakpoint fired. Software programs the channels and clears the hit bits through a simple register write/read port.

Top module: `brk_match_unit`

## Requirements
- R1: After reset every channel is disabled, every hit bit is 0, `brk_req_o` is 0 and every register reads 0.
- R2: An enabled instruction channel matches when `fetch_vld_i` is high and `fetch_addr_i` equals its address register on all bits that the mask does not ignore. Instruction channels never react to load/store traffic.
- R3: In the address mask and the value mask a 1 bit means "ignore this bit". A channel matches when ((observed XOR programmed) AND NOT mask) is zero, so one channel can cover a range of addresses.
- R4: A channel whose enable bit is 0 never matches and never sets its hit bit, whatever the inputs are.
- R5: A data channel matches only on `mem_vld_i`. Control bit 1 allows loads (`mem_store_i`=0) and control bit 2 allows stores (`mem_store_i`=1). With both bits set it matches either kind, and with neither set it matches nothing.
- R6: When control bit 3 (value compare) of a data channel is set, `mem_data_i` must also match the value register under the value mask. When it is clear, the data bus is ignored.
- R7: `brk_req_o` is combinational: it is high in the same cycle as the strobe exactly when at least one enabled channel matches, and it is low in any cycle without a strobe.
- R8: A channel's hit bit (status register, bit 0) is set at the clock edge that ends a matching cycle and stays set until a write of 1 to that bit. Writing 0 leaves it unchanged. A match in the same cycle as a clearing write leaves it set.
- R9: Register address = {channel, register index}, with the index in the low 3 bits. Channels 0-5 are instruction channels and channels 6-7 are data channels. Indices: 0 control (bit 0 enable, 1 load, 2 store, 3 value compare), 1 address, 2 address mask, 3 value, 4 value mask, 5 status. Written values read back. For instruction channels, indices 3 and 4 and control bits 3:1 read 0.
- R10: Bit c of `hit_o` is the hit bit of channel c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 6 | Register address {channel, index} |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data (combinational on address) |
| fetch_vld_i | input | 1 | Instruction fetch strobe |
| fetch_addr_i | input | 32 | Fetch virtual address |
| mem_vld_i | input | 1 | Load/store strobe |
| mem_store_i | input | 1 | 1 = store, 0 = load |
| mem_addr_i | input | 32 | Access virtual address |
| mem_data_i | input | 32 | Load/store data value |
| brk_req_o | output | 1 | Debug break request |
| hit_o | output | 8 | Sticky per-channel hit status |

## Verification
The break request has no register on its path, so it is due in the very cycle the strobe is driven. The bench drives fetches and accesses just after a falling edge and samples `brk_req_o` 1 ns later, before the next rising edge. A hit bit changes at the first rising edge after the strobe, so `hit_o` is sampled at the following falling edge. Register writes take effect on the rising edge inside the write window. Reads are combinational and are sampled 1 ns after the address settles.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  localparam int CFG_DW = 32;
  localparam int IDX_W  = 3;

  localparam logic [IDX_W-1:0] RI_CTRL  = 3'd0;
  localparam logic [IDX_W-1:0] RI_ADDR  = 3'd1;
  localparam logic [IDX_W-1:0] RI_AMASK = 3'd2;
  localparam logic [IDX_W-1:0] RI_VAL   = 3'd3;
  localparam logic [IDX_W-1:0] RI_VMASK = 3'd4;
  localparam logic [IDX_W-1:0] RI_STAT  = 3'd5;

  localparam int CB_EN = 0;
  localparam int CB_LD = 1;
  localparam int CB_ST = 2;
  localparam int CB_VC = 3;
endpackage

// File: rtl/bpu_mask_cmp.sv
module bpu_mask_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] obs_i,
  input  logic [W-1:0] ref_i,
  input  logic [W-1:0] ign_i,
  output logic         eq_o
);
  assign eq_o = ((obs_i ^ ref_i) & ~ign_i) == '0;
endmodule

// File: rtl/bpu_chan.sv
module bpu_chan
  import bpu_pkg::*;
#(
  parameter bit IS_DATA = 1'b0,
  parameter int AW      = 32,
  parameter int DW      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [CFG_DW-1:0] wdata_i,
  output logic [CFG_DW-1:0] rdata_o,
  input  logic              strobe_i,
  input  logic              is_store_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     data_i,
  output logic              match_o,
  output logic              hit_o
);
  logic          en_q, hit_q, hit_clr;
  logic [AW-1:0] addr_q, amask_q;
  logic          addr_eq, kind_ok, val_ok;
  logic [2:0]    ext_ctrl;
  logic [CFG_DW-1:0] ext_val, ext_vmask;

  bpu_mask_cmp #(.W(AW)) i_acmp (
    .obs_i(addr_i), .ref_i(addr_q), .ign_i(amask_q), .eq_o(addr_eq)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      addr_q  <= '0;
      amask_q <= '0;
    end else if (we_i) begin
      case (idx_i)
        RI_CTRL:  en_q    <= wdata_i[CB_EN];
        RI_ADDR:  addr_q  <= wdata_i[AW-1:0];
        RI_AMASK: amask_q <= wdata_i[AW-1:0];
        default: ;
      endcase
    end
  end

  generate
    if (IS_DATA) begin : g_data
      logic          ld_q, st_q, vc_q, val_eq;
      logic [DW-1:0] val_q, vmask_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          ld_q    <= 1'b0;
          st_q    <= 1'b0;
          vc_q    <= 1'b0;
          val_q   <= '0;
          vmask_q <= '0;
        end else if (we_i) begin
          case (idx_i)
            RI_CTRL: begin
              ld_q <= wdata_i[CB_LD];
              st_q <= wdata_i[CB_ST];
              vc_q <= wdata_i[CB_VC];
            end
            RI_VAL:   val_q   <= wdata_i[DW-1:0];
            RI_VMASK: vmask_q <= wdata_i[DW-1:0];
            default: ;
          endcase
        end
      end

      bpu_mask_cmp #(.W(DW)) i_vcmp (
        .obs_i(data_i), .ref_i(val_q), .ign_i(vmask_q), .eq_o(val_eq)
      );

      assign kind_ok   = is_store_i ? st_q : ld_q;
      assign val_ok    = !vc_q || val_eq;
      assign ext_ctrl  = {vc_q, st_q, ld_q};
      assign ext_val   = CFG_DW'(val_q);
      assign ext_vmask = CFG_DW'(vmask_q);

      // r5: access kind must be permitted by the control bits
      a_r5_kind_allowed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o |-> (is_store_i ? st_q : ld_q));
    end else begin : g_insn
      logic unused_in;
      assign unused_in = ^{data_i, is_store_i};
      assign kind_ok   = 1'b1;
      assign val_ok    = 1'b1;
      assign ext_ctrl  = '0;
      assign ext_val   = '0;
      assign ext_vmask = '0;
    end
  endgenerate

  assign match_o = strobe_i && en_q && addr_eq && kind_ok && val_ok;
  assign hit_clr = we_i && (idx_i == RI_STAT) && wdata_i[0];

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= match_o || (hit_q && !hit_clr);
  end

  assign hit_o = hit_q;

  always_comb begin
    case (idx_i)
      RI_CTRL:  rdata_o = CFG_DW'({ext_ctrl, en_q});
      RI_ADDR:  rdata_o = CFG_DW'(addr_q);
      RI_AMASK: rdata_o = CFG_DW'(amask_q);
      RI_VAL:   rdata_o = ext_val;
      RI_VMASK: rdata_o = ext_vmask;
      RI_STAT:  rdata_o = CFG_DW'(hit_q);
      default:  rdata_o = '0;
    endcase
  end

  a_r4_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !match_o);
  a_r7_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> strobe_i);
  a_r8_hit_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> hit_o);
  a_r8_hit_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hit_o) |-> $past(match_o));
  a_r8_hit_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !hit_clr) |=> hit_o);
endmodule

// File: rtl/brk_match_unit.sv
module brk_match_unit
  import bpu_pkg::*;
#(
  parameter  int N_INSN = 6,
  parameter  int N_DATA = 2,
  parameter  int AW     = 32,
  parameter  int DW     = 32,
  localparam int N_CH   = N_INSN + N_DATA,
  localparam int CH_W   = $clog2(N_CH),
  localparam int RA_W   = CH_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [RA_W-1:0]   cfg_addr_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  output logic [CFG_DW-1:0] cfg_rdata_o,
  input  logic              fetch_vld_i,
  input  logic [AW-1:0]     fetch_addr_i,
  input  logic              mem_vld_i,
  input  logic              mem_store_i,
  input  logic [AW-1:0]     mem_addr_i,
  input  logic [DW-1:0]     mem_data_i,
  output logic              brk_req_o,
  output logic [N_CH-1:0]   hit_o
);
  logic [CH_W-1:0]   ch_sel;
  logic [IDX_W-1:0]  reg_idx;
  logic [N_CH-1:0]   ch_match;
  logic [CFG_DW-1:0] ch_rdata [N_CH];

  assign ch_sel  = cfg_addr_i[RA_W-1:IDX_W];
  assign reg_idx = cfg_addr_i[IDX_W-1:0];

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      localparam bit DATA = (c >= N_INSN);
      bpu_chan #(.IS_DATA(DATA), .AW(AW), .DW(DW)) i_chan (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (cfg_we_i && (ch_sel == CH_W'(c))),
        .idx_i     (reg_idx),
        .wdata_i   (cfg_wdata_i),
        .rdata_o   (ch_rdata[c]),
        .strobe_i  (DATA ? mem_vld_i : fetch_vld_i),
        .is_store_i(DATA ? mem_store_i : 1'b0),
        .addr_i    (DATA ? mem_addr_i : fetch_addr_i),
        .data_i    (DATA ? mem_data_i : '0),
        .match_o   (ch_match[c]),
        .hit_o     (hit_o[c])
      );
    end
  endgenerate

  always_comb begin
    cfg_rdata_o = '0;
    for (int c = 0; c < N_CH; c++)
      if (ch_sel == CH_W'(c)) cfg_rdata_o = ch_rdata[c];
  end

  assign brk_req_o = |ch_match;

  a_r7_req_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_req_o |-> (fetch_vld_i || mem_vld_i));
  a_r10_hit_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !brk_req_o |=> ($countones(hit_o) <= $countones($past(hit_o))));
endmodule

// File: tb/test_brk_match_unit.sv
`timescale 1ns/1ps
module test_brk_match_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        fetch_vld = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        mem_vld = 1'b0;
  logic        mem_store = 1'b0;
  logic [31:0] mem_addr = '0;
  logic [31:0] mem_data = '0;
  logic        brk_req;
  logic [7:0]  hit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  brk_match_unit i_brk_match_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata),
    .fetch_vld_i(fetch_vld), .fetch_addr_i(fetch_addr),
    .mem_vld_i(mem_vld), .mem_store_i(mem_store),
    .mem_addr_i(mem_addr), .mem_data_i(mem_data),
    .brk_req_o(brk_req), .hit_o(hit)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int ri, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {3'(ch), 3'(ri)}; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int ch, input int ri, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = {3'(ch), 3'(ri)};
    #1 chk(tag, cfg_rdata, exp);
  endtask

  task automatic fetch(input logic [31:0] a, input logic exp, input string tag);
    @(negedge clk);
    fetch_vld = 1'b1; fetch_addr = a;
    #1 chk(tag, 32'(brk_req), 32'(exp));
    @(negedge clk);
    fetch_vld = 1'b0;
  endtask

  task automatic access(input logic st, input logic [31:0] a, input logic [31:0] d,
                        input logic exp, input string tag);
    @(negedge clk);
    mem_vld = 1'b1; mem_store = st; mem_addr = a; mem_data = d;
    #1 chk(tag, 32'(brk_req), 32'(exp));
    @(negedge clk);
    mem_vld = 1'b0;
  endtask

  task automatic clr_all();
    for (int c = 0; c < 8; c++) wr(c, 5, 32'h1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 brk_req after reset", 32'(brk_req), 0);
    chk("R1 hit after reset", 32'(hit), 0);
    rd(0, 0, 0, "R1 ch0 ctrl reset");
    rd(6, 5, 0, "R1 ch6 status reset");
    fetch(32'h0, 1'b0, "R4 disabled ch0 at addr 0");
    access(1'b0, 32'h0, 32'h0, 1'b0, "R4 disabled ch6 at addr 0");
    chk("R4 no hit while disabled", 32'(hit), 0);
  endtask

  task automatic t_readback();
    wr(2, 1, 32'h1234_5678);
    rd(2, 1, 32'h1234_5678, "R9 ch2 addr readback");
    wr(6, 4, 32'hCAFE_0F0F);
    rd(6, 4, 32'hCAFE_0F0F, "R9 ch6 vmask readback");
    wr(1, 3, 32'hFFFF_FFFF);
    rd(1, 3, 0, "R9 insn value reg reads 0");
    wr(1, 0, 32'hF);
    rd(1, 0, 32'h1, "R9 insn ctrl upper bits 0");
    wr(7, 0, 32'hE);
    rd(7, 0, 32'hE, "R9 data ctrl readback");
    wr(1, 0, 0);
    wr(7, 0, 0);
  endtask

  task automatic t_insn_exact();
    wr(0, 1, 32'h0000_1000);
    wr(0, 0, 32'h1);
    fetch(32'h0000_1000, 1'b1, "R2 exact fetch match");
    chk("R10 hit bit0 set", 32'(hit), 32'h01);
    fetch(32'h0000_1004, 1'b0, "R2 other address no match");
    access(1'b0, 32'h0000_1000, 0, 1'b0, "R2 insn ignores loads");
    clr_all();
    chk("R8 cleared", 32'(hit), 0);
  endtask

  task automatic t_mask();
    wr(3, 1, 32'h0000_2000);
    wr(3, 2, 32'h0000_00FF);
    wr(3, 0, 32'h1);
    fetch(32'h0000_20A4, 1'b1, "R3 inside masked range");
    fetch(32'h0000_2100, 1'b0, "R3 outside masked range");
    chk("R10 hit bit3 set", 32'(hit), 32'h08);
    fetch(32'h0000_1000, 1'b1, "R7 OR of channels (ch0)");
    chk("R10 hits ch0 and ch3", 32'(hit), 32'h09);
    @(negedge clk);
    fetch_addr = 32'h0000_1000;
    #1 chk("R7 no req without strobe", 32'(brk_req), 0);
  endtask

  task automatic t_w1c();
    wr(3, 5, 32'h0);
    chk("R8 write 0 keeps hit", 32'(hit), 32'h09);
    wr(3, 5, 32'h1);
    chk("R8 write 1 clears hit", 32'(hit), 32'h01);
    @(negedge clk);
    fetch_vld = 1'b1; fetch_addr = 32'h0000_20A4;
    cfg_we = 1'b1; cfg_addr = {3'd3, 3'd5}; cfg_wdata = 32'h1;
    @(negedge clk);
    fetch_vld = 1'b0; cfg_we = 1'b0;
    chk("R8 set wins over clear", 32'(hit), 32'h09);
  endtask

  task automatic t_disable();
    clr_all();
    wr(0, 0, 32'h0);
    fetch(32'h0000_1000, 1'b0, "R4 disabled after match setup");
    chk("R4 no hit when disabled", 32'(hit), 0);
    wr(3, 0, 32'h0);
  endtask

  task automatic t_dtype();
    wr(6, 1, 32'h0000_3000);
    wr(6, 4, 32'h0);
    wr(6, 0, 32'h3);
    access(1'b0, 32'h0000_3000, 0, 1'b1, "R5 load-only on load");
    access(1'b1, 32'h0000_3000, 0, 1'b0, "R5 load-only on store");
    wr(6, 0, 32'h5);
    access(1'b1, 32'h0000_3000, 0, 1'b1, "R5 store-only on store");
    access(1'b0, 32'h0000_3000, 0, 1'b0, "R5 store-only on load");
    wr(6, 0, 32'h7);
    access(1'b0, 32'h0000_3000, 0, 1'b1, "R5 both on load");
    access(1'b1, 32'h0000_3000, 0, 1'b1, "R5 both on store");
    fetch(32'h0000_3000, 1'b0, "R5 data ch ignores fetch");
    wr(6, 0, 32'h1);
    access(1'b0, 32'h0000_3000, 0, 1'b0, "R5 neither kind load");
    access(1'b1, 32'h0000_3000, 0, 1'b0, "R5 neither kind store");
    chk("R10 hit bit6", 32'(hit), 32'h40);
    wr(6, 0, 32'h0);
    clr_all();
  endtask

  task automatic t_dvalue();
    wr(7, 1, 32'h0000_4000);
    wr(7, 3, 32'h0000_AB00);
    wr(7, 4, 32'h0000_00FF);
    wr(7, 0, 32'hF);
    access(1'b1, 32'h0000_4000, 32'h0000_AB37, 1'b1, "R6 value match under mask");
    access(1'b1, 32'h0000_4000, 32'h0000_AC00, 1'b0, "R6 value mismatch");
    access(1'b0, 32'h0000_4000, 32'h1234_AB00, 1'b0, "R6 high bits mismatch");
    chk("R10 hit bit7", 32'(hit), 32'h80);
    wr(7, 0, 32'h7);
    access(1'b0, 32'h0000_4000, 32'hFFFF_FFFF, 1'b1, "R6 data ignored when compare off");
    access(1'b0, 32'h0000_4001, 32'h0000_AB00, 1'b0, "R6 address still required");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readback();
    t_insn_exact();
    t_mask();
    t_w1c();
    t_disable();
    t_dtype();
    t_dvalue();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule